// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block computes the product C = A·B of two square N×N matrices of unsigned W-bit operands on an N×N grid of multiply-accumulate cells. Each result element stays in the cell that computes it. Operands travel through the grid: elements of A move rightward and elements of B move downward, one cell per clock. Each cell multiplies the pair of values that arrives in a cycle and adds the product to its own running sum.

The user pulses `start`. For the next N cycles the user presents one column of A and the matching row of B on the operand ports. The block inserts the staggering itself. Row i of A is held back by i cycles at the left edge, and column j of B is held back by j cycles at the top edge. Zeros fill the empty slots. A controller counts a fixed schedule and raises `done` once the whole product is present. All N² sums stay readable in parallel until the next accepted start.

Top module: `sysmm_top`

## Requirements
- R1: While and after reset, with no start accepted yet, `busy` and `done` are low and every result field reads zero.
- R2: A `start` sampled high while `busy` is low is accepted. After that edge every result field reads zero, `busy` is high and `done` is low.
- R3: Operand slice k (k = 0..N-1) is sampled on the (k+1)-th rising edge after acceptance. `aColIn[i*W +: W]` carries A[i][k] and `bRowIn[j*W +: W]` carries B[k][j].
- R4: After the c-th rising edge following acceptance, field `cFlat[(i*N+j)*ACCW +: ACCW]` holds the sum of A[i][k]·B[k][j] over k = 0 .. min(N-1, c-1-i-j). The field is zero when that range is empty.
- R5: `done` rises and `busy` falls on exactly the (3N-1)-th rising edge after acceptance.
- R6: Once `done` is high, it and every result field hold their values until the next accepted start.
- R7: Operand port values outside the N sampling edges of R3 have no effect on any result.
- R8: A `start` pulse while `busy` is high is ignored. The schedule and the results of the running multiplication are unchanged.
- R9: Results are exact for all-maximum operands. Each field reaches N·(2^W-1)² without wrap, in an accumulator of 2W+log2(N) bits.
- R10: `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; ignored while busy |
| aColIn | input | N*W | Column k of A, row i in bits i*W |
| bRowIn | input | N*W | Row k of B, column j in bits j*W |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | All results valid; held until the next start |
| cFlat | output | N*N*ACCW | Result C[i][j] in bits (i*N+j)*ACCW |

## Verification
The bench checks every result field on every cycle against partial sums that depend on the diagonal index i+j. A mistake in the skew depth or the forwarding delay therefore shows up as a wrong partial sum long before `done`, rather than only as a wrong final matrix. Random values are driven on the operand ports outside the sampling window. A design that sampled those ports, or let a late slice through, would add extra products. A start pulse inside a run would, in a faulty design, restart the schedule or wipe the sums. An off-by-one schedule counter would move `done` one cycle away from 3N-1. All-maximum operands expose an accumulator that is one bit too narrow. A back-to-back second run exposes a missing clear of the previous results.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;
  // strobes sent from the sequencer to the datapath each cycle
  typedef struct packed {
    logic clearAll;   // zero accumulators and staggering registers
    logic feedEn;     // operand ports are inside the sampling window
  } mmStrobes_t;
endpackage

// File: rtl/sysmm_cell.sv
module sysmm_cell #(
  parameter int W    = 8,
  parameter int ACCW = 18
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clear,
  input  logic [W-1:0]    aLeft,
  input  logic [W-1:0]    bUp,
  output logic [W-1:0]    aRight,
  output logic [W-1:0]    bDown,
  output logic [ACCW-1:0] acc
);
  logic [2*W-1:0] prod;
  assign prod = {{W{1'b0}}, aLeft} * {{W{1'b0}}, bUp};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aRight <= '0;
      bDown  <= '0;
      acc    <= '0;
    end else if (clear) begin
      aRight <= '0;
      bDown  <= '0;
      acc    <= '0;
    end else begin
      aRight <= aLeft;
      bDown  <= bUp;
      acc    <= acc + ACCW'(prod);
    end
  end
endmodule

// File: rtl/sysmm_skew.sv
module sysmm_skew #(
  parameter int W     = 8,
  parameter int DEPTH = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_chain
      logic [W-1:0] stage [DEPTH];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int s = 0; s < DEPTH; s++) stage[s] <= '0;
        end else if (clear) begin
          for (int s = 0; s < DEPTH; s++) stage[s] <= '0;
        end else begin
          stage[0] <= din;
          for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
        end
      end
      assign dout = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sysmm_datapath.sv
module sysmm_datapath
  import sysmm_pkg::*;
#(
  parameter int N    = 4,
  parameter int W    = 8,
  parameter int ACCW = 2*W + $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mmStrobes_t        strobes,
  input  logic [N*W-1:0]    aColIn,
  input  logic [N*W-1:0]    bRowIn,
  output logic [N*N*ACCW-1:0] cFlat
);
  // horizontal links: aLink[i][j] enters cell (i,j); column N is the unused exit
  logic [W-1:0] aLink [N][N+1];
  logic [W-1:0] bLink [N+1][N];

  genvar i, j;
  generate
    for (i = 0; i < N; i++) begin : g_edge
      logic [W-1:0] aGated, bGated;
      assign aGated = strobes.feedEn ? aColIn[i*W +: W] : '0;
      assign bGated = strobes.feedEn ? bRowIn[i*W +: W] : '0;

      sysmm_skew #(.W(W), .DEPTH(i)) u_skewA (
        .clk(clk), .rstN(rstN), .clear(strobes.clearAll),
        .din(aGated), .dout(aLink[i][0])
      );
      sysmm_skew #(.W(W), .DEPTH(i)) u_skewB (
        .clk(clk), .rstN(rstN), .clear(strobes.clearAll),
        .din(bGated), .dout(bLink[0][i])
      );
    end

    for (i = 0; i < N; i++) begin : g_row
      for (j = 0; j < N; j++) begin : g_col
        sysmm_cell #(.W(W), .ACCW(ACCW)) u_cell (
          .clk(clk), .rstN(rstN), .clear(strobes.clearAll),
          .aLeft(aLink[i][j]), .bUp(bLink[i][j]),
          .aRight(aLink[i][j+1]), .bDown(bLink[i+1][j]),
          .acc(cFlat[(i*N+j)*ACCW +: ACCW])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/sysmm_ctrl.sv
module sysmm_ctrl
  import sysmm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mmStrobes_t strobes,
  output logic       busy,
  output logic       done
);
  localparam int LAST = 3*N - 1;
  localparam int CNTW = $clog2(LAST + 1) + 1;

  logic [CNTW-1:0] cnt;
  logic            accept;

  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= CNTW'(1);
    end else if (busy) begin
      if (cnt == CNTW'(LAST)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strobes.clearAll = accept;
    strobes.feedEn   = busy && (cnt >= CNTW'(1)) && (cnt <= CNTW'(N));
  end
endmodule

// File: rtl/sysmm_top.sv
module sysmm_top
  import sysmm_pkg::*;
#(
  parameter int N    = 4,
  parameter int W    = 8,
  parameter int ACCW = 2*W + $clog2(N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [N*W-1:0]      aColIn,
  input  logic [N*W-1:0]      bRowIn,
  output logic                busy,
  output logic                done,
  output logic [N*N*ACCW-1:0] cFlat
);
  mmStrobes_t strobes;

  sysmm_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobes(strobes), .busy(busy), .done(done)
  );

  sysmm_datapath #(.N(N), .W(W), .ACCW(ACCW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .aColIn(aColIn), .bRowIn(bRowIn), .cFlat(cFlat)
  );
endmodule

// File: rtl/sysmm_chk.sv
module sysmm_chk #(
  parameter int N    = 4,
  parameter int W    = 8,
  parameter int ACCW = 2*W + $clog2(N)
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [N*N*ACCW-1:0] cFlat
);
  localparam int LAST = 3*N - 1;
  localparam int CNTW = $clog2(LAST + 1) + 2;

  // independent count of edges since acceptance
  logic [CNTW-1:0] runCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                runCnt <= '0;
    else if (start && !busy)  runCnt <= CNTW'(1);
    else if (busy)            runCnt <= runCnt + 1'b1;
  end

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R2
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (cFlat == '0) && busy && !done);

  // R5
  done_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && runCnt == CNTW'(LAST)) |=> (done && !busy));

  // R5
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && runCnt < CNTW'(LAST)) |=> (!done && busy));

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(cFlat)));
endmodule

bind sysmm_top sysmm_chk #(.N(N), .W(W), .ACCW(ACCW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start),
  .busy(busy), .done(done), .cFlat(cFlat)
);

// File: tb/sim_sysmm_top.sv
module sim_sysmm_top;
  localparam int N    = 4;
  localparam int W    = 8;
  localparam int ACCW = 2*W + $clog2(N);
  localparam int LAST = 3*N - 1;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic [N*W-1:0]      aColIn = '0;
  logic [N*W-1:0]      bRowIn = '0;
  logic                busy, done;
  logic [N*N*ACCW-1:0] cFlat;

  int matA [N][N];
  int matB [N][N];
  int total = 0;
  int failed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  sysmm_top #(.N(N), .W(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .aColIn(aColIn), .bRowIn(bRowIn),
    .busy(busy), .done(done), .cFlat(cFlat)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint field(input int i, input int j);
    return longint'(cFlat[(i*N+j)*ACCW +: ACCW]);
  endfunction

  // partial sum held by cell (i,j) after the c-th edge since acceptance
  function automatic longint partial(input int i, input int j, input int c);
    longint s = 0;
    for (int k = 0; k < N; k++)
      if (k <= c - 1 - i - j) s += longint'(matA[i][k]) * longint'(matB[k][j]);
    return s;
  endfunction

  task automatic driveGarbage();
    for (int r = 0; r < N; r++) begin
      aColIn[r*W +: W] = W'($urandom);
      bRowIn[r*W +: W] = W'($urandom);
    end
  endtask

  // mode: 0 random, 1 identity times random, 2 all max, 3 zero
  task automatic fillMats(input int mode);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        case (mode)
          1: begin matA[i][j] = (i == j) ? 1 : 0; matB[i][j] = int'($urandom_range(0, 255)); end
          2: begin matA[i][j] = (1 << W) - 1; matB[i][j] = (1 << W) - 1; end
          3: begin matA[i][j] = 0; matB[i][j] = int'($urandom_range(0, 255)); end
          default: begin matA[i][j] = int'($urandom_range(0, 255)); matB[i][j] = int'($urandom_range(0, 255)); end
        endcase
      end
  endtask

  task automatic runMult(input string finalReq, input bit pokeStart);
    @(negedge clk);
    start = 1'b1;
    driveGarbage();                         // R7: not sampled at acceptance
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= LAST + 3; c++) begin
      // cycle-by-cycle comparison against the behavioural model
      check(busy == (c < LAST), (c == 0) ? "R2" : "R5", busy, (c < LAST));
      check(done == (c >= LAST), (c >= LAST) ? "R6" : "R5", done, (c >= LAST));
      check(!(busy && done), "R10", busy && done, 0);
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          string tag;
          if (c == 0) tag = "R2";
          else if (c >= LAST) tag = finalReq;
          else tag = "R4";
          check(field(i, j) == partial(i, j, c), tag, field(i, j), partial(i, j, c));
        end
      if (c < N) begin
        // R3: slice c sampled on edge c+1
        for (int r = 0; r < N; r++) begin
          aColIn[r*W +: W] = W'(matA[r][c]);
          bRowIn[r*W +: W] = W'(matB[c][r]);
        end
      end else begin
        driveGarbage();                     // R7: outside the window
      end
      start = pokeStart && (c == N + 1);    // R8: start while busy
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failed++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    fillMats(0);
    repeat (3) @(negedge clk);
    // R1: reset values
    check(busy == 1'b0, "R1", busy, 0);
    check(done == 1'b0, "R1", done, 0);
    check(cFlat == '0, "R1", (cFlat == '0), 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    driveGarbage();
    @(negedge clk);
    check(!busy && !done && cFlat == '0, "R1", busy || done, 0);

    fillMats(0); runMult("R4", 1'b0);
    fillMats(1); runMult("R4", 1'b1);   // R8 during this run
    fillMats(2); runMult("R9", 1'b0);
    fillMats(3); runMult("R4", 1'b0);
    fillMats(0); runMult("R6", 1'b1);

    // R6 and R7: long idle with noisy operand ports, results held
    for (int t = 0; t < 5; t++) begin
      driveGarbage();
      @(negedge clk);
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          check(field(i, j) == partial(i, j, LAST), "R7", field(i, j), partial(i, j, LAST));
      check(done && !busy, "R6", done, 1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule